// File: doc/BRIEF.md
# Microprogram Sequencer with Jump Logic

This block is the control unit for a 32-bit datapath in which all registers share one bus. A six-bit micro-address register selects one word of a control store. Each word supplies seventeen datapath control bits, which cover one bus transfer per cycle, and a three-bit jump code. The jump code tells the next-address logic how to pick the following micro-address. There is no next-address field in the word.

The jump codes have these meanings:
- step: go to the following word.
- stall: hold while memory reports busy.
- return: go back to the start of the instruction-fetch routine.
- dispatch: go to the entry of the routine for the current opcode.
- zero-tested jumps: go back to fetch, or continue, depending on the ALU zero flag.

The stored microprogram covers instruction fetch, register and immediate ALU operations, load, store, the two zero-test branches, and the four jump forms. The datapath, memory and register file sit outside the block. They take the control bits and return the zero flag, the memory busy flag and the opcode of the instruction register.

Top module: `ucode_sequencer`

## Requirements
- R1: While reset is applied, and until the sequencer has started, every load, bus-enable and write output is 0 and `upc` is 0. The first active word is the fetch start at address 0. Reset takes effect asynchronously.
- R2: A word with the step code makes `upc` advance by one on the next clock.
- R3: A word with the stall code (addresses 1, 13 and 18) holds `upc` while `busy` is 1. It advances by one on the first clock at which `busy` is 0.
- R4: A word with the return code sends `upc` to 0 on the next clock.
- R5: The dispatch word at address 3 jumps to the routine entry for the opcode. The entries are: 0 ALU→4, 1 ALU-immediate→7, 2 load→10, 3 store→15, 4 branch-if-zero→20, 5 branch-if-nonzero→25, 6 jump→30, 7 jump-register→33, 8 jump-and-link→36, 9 jump-and-link-register→41. Any other opcode goes to 0.
- R6: Address 21 (branch-if-zero) continues to 22 when `zero` is 1 and returns to 0 otherwise. Address 26 (branch-if-nonzero) returns to 0 when `zero` is 1 and continues to 27 otherwise.
- R7: The fetch routine drives its transfers in this order, with `reg_sel` code 4 meaning PC:
  - address 0: `reg_sel`=4, `en_reg`, `ld_ma`;
  - address 1: `en_mem`, `ld_ir`;
  - address 2: `reg_sel`=4, `en_reg`, `ld_a`;
  - address 3: `en_alu` with `alu_op`=2 (A+4), `reg_wr`, `reg_sel`=4.
- R8: The load routine drives these transfers:
  - address 11 loads B from the sign-extended immediate (`en_imm`, `ld_b`, `ext_sel`=0);
  - address 12 loads MA with A+B (`en_alu`, `alu_op`=0, `ld_ma`);
  - address 13 writes memory data to rt (`en_mem`, `reg_wr`, `reg_sel`=1).
- R9: The branch routines load B from the sign-extended immediate shifted left by 2 (`ext_sel`=2, `en_imm`, `ld_b`) at addresses 23 and 28.
- R10: In every cycle at most one of `en_imm`, `en_alu`, `en_mem` and `en_reg` is 1.
- R11: The link routines write the sum A+B to the link register (`reg_sel`=3, `reg_wr`, `en_alu`, `alu_op`=0) at addresses 38 and 43.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 6 | Opcode of the current instruction |
| zero | input | 1 | ALU zero flag |
| busy | input | 1 | Memory busy |
| ld_ir | output | 1 | Load instruction register from bus |
| ld_a | output | 1 | Load operand A from bus |
| ld_b | output | 1 | Load operand B from bus |
| ld_ma | output | 1 | Load memory address register from bus |
| en_imm | output | 1 | Immediate extender drives bus |
| en_alu | output | 1 | ALU drives bus |
| en_mem | output | 1 | Memory drives bus |
| en_reg | output | 1 | Register file drives bus |
| mem_wr | output | 1 | Write bus value to memory |
| reg_wr | output | 1 | Write bus value to selected register |
| reg_sel | output | 3 | Register select: 0 rs, 1 rt, 2 rd, 3 link, 4 PC |
| alu_op | output | 2 | ALU function: 0 add, 1 per instruction, 2 A+4, 3 jump target join |
| ext_sel | output | 2 | Extender: 0 signed, 1 zero constant, 2 signed shifted by 2, 3 jump field |
| upc | output | 6 | Current micro-address |

## Verification
The hardest cases to reach are the stall words that come in the middle of a routine, and the zero-tested branch words. Each is visited only after fetch has completed and after the right opcode has been dispatched. The stimulus first lets fetch run and holds `busy` high across the instruction-read stall. It then dispatches a load and holds `busy` again at the memory-read word. A table of opcode and zero-flag pairs walks every routine from dispatch back to fetch, so both outcomes of each branch are taken. The bench checks the dispatch target and the total routine length for each pair.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int UPC_W  = 6;
  localparam int OPC_W  = 6;
  localparam int RSEL_W = 3;
  localparam int OP_W   = 2;
  localparam int EXT_W  = 2;

  typedef logic [UPC_W-1:0] upc_t;

  typedef enum logic [2:0] {
    JT_NEXT, JT_SPIN, JT_FETCH, JT_DISP, JT_FEQZ, JT_FNEZ
  } jump_e;

  typedef struct packed {
    logic              ld_ir;
    logic              ld_a;
    logic              ld_b;
    logic              ld_ma;
    logic              en_imm;
    logic              en_alu;
    logic              en_mem;
    logic              en_reg;
    logic              mem_wr;
    logic              reg_wr;
    logic [RSEL_W-1:0] reg_sel;
    logic [OP_W-1:0]   alu_op;
    logic [EXT_W-1:0]  ext_sel;
  } uctl_t;

  localparam logic [RSEL_W-1:0] RS_RS = 3'd0, RS_RT = 3'd1, RS_RD = 3'd2,
                                RS_LINK = 3'd3, RS_PC = 3'd4;
  localparam logic [OP_W-1:0]   OP_ADD = 2'd0, OP_FUNC = 2'd1, OP_INC4 = 2'd2,
                                OP_JOIN = 2'd3;
  localparam logic [EXT_W-1:0]  EX_SEXT = 2'd0, EX_ZERO = 2'd1, EX_SH2 = 2'd2,
                                EX_JT = 2'd3;

  localparam upc_t FETCH_ENTRY = '0;

  function automatic upc_t dispatch_entry(input logic [OPC_W-1:0] opc);
    case (opc)
      6'd0:    return upc_t'(4);
      6'd1:    return upc_t'(7);
      6'd2:    return upc_t'(10);
      6'd3:    return upc_t'(15);
      6'd4:    return upc_t'(20);
      6'd5:    return upc_t'(25);
      6'd6:    return upc_t'(30);
      6'd7:    return upc_t'(33);
      6'd8:    return upc_t'(36);
      6'd9:    return upc_t'(41);
      default: return FETCH_ENTRY;
    endcase
  endfunction
endpackage

// File: rtl/ucode_store.sv
module ucode_store
  import useq_pkg::*;
(
  input  upc_t  addr,
  output uctl_t ctl,
  output jump_e jump
);
  always_comb begin
    ctl = '0;
    case (addr)
      6'd0:                         begin ctl.reg_sel = RS_PC; ctl.en_reg = 1'b1; ctl.ld_ma = 1'b1; end
      6'd1:                         begin ctl.en_mem = 1'b1; ctl.ld_ir = 1'b1; end
      6'd2, 6'd22, 6'd27, 6'd30,
      6'd36, 6'd41:                 begin ctl.reg_sel = RS_PC; ctl.en_reg = 1'b1; ctl.ld_a = 1'b1; end
      6'd3:                         begin ctl.en_alu = 1'b1; ctl.alu_op = OP_INC4; ctl.reg_wr = 1'b1; ctl.reg_sel = RS_PC; end
      6'd4, 6'd7, 6'd10, 6'd15,
      6'd20, 6'd25, 6'd33, 6'd44:   begin ctl.reg_sel = RS_RS; ctl.en_reg = 1'b1; ctl.ld_a = 1'b1; end
      6'd5:                         begin ctl.reg_sel = RS_RT; ctl.en_reg = 1'b1; ctl.ld_b = 1'b1; end
      6'd6:                         begin ctl.en_alu = 1'b1; ctl.alu_op = OP_FUNC; ctl.reg_wr = 1'b1; ctl.reg_sel = RS_RD; end
      6'd8, 6'd11, 6'd16:           begin ctl.en_imm = 1'b1; ctl.ext_sel = EX_SEXT; ctl.ld_b = 1'b1; end
      6'd9:                         begin ctl.en_alu = 1'b1; ctl.alu_op = OP_FUNC; ctl.reg_wr = 1'b1; ctl.reg_sel = RS_RT; end
      6'd12, 6'd17:                 begin ctl.en_alu = 1'b1; ctl.alu_op = OP_ADD; ctl.ld_ma = 1'b1; end
      6'd13:                        begin ctl.en_mem = 1'b1; ctl.reg_wr = 1'b1; ctl.reg_sel = RS_RT; end
      6'd18:                        begin ctl.en_reg = 1'b1; ctl.reg_sel = RS_RT; ctl.mem_wr = 1'b1; end
      6'd23, 6'd28:                 begin ctl.en_imm = 1'b1; ctl.ext_sel = EX_SH2; ctl.ld_b = 1'b1; end
      6'd24, 6'd29, 6'd35, 6'd45:   begin ctl.en_alu = 1'b1; ctl.alu_op = OP_ADD; ctl.reg_wr = 1'b1; ctl.reg_sel = RS_PC; end
      6'd31, 6'd39:                 begin ctl.en_imm = 1'b1; ctl.ext_sel = EX_JT; ctl.ld_b = 1'b1; end
      6'd32, 6'd40:                 begin ctl.en_alu = 1'b1; ctl.alu_op = OP_JOIN; ctl.reg_wr = 1'b1; ctl.reg_sel = RS_PC; end
      6'd34, 6'd37, 6'd42:          begin ctl.en_imm = 1'b1; ctl.ext_sel = EX_ZERO; ctl.ld_b = 1'b1; end
      6'd38, 6'd43:                 begin ctl.en_alu = 1'b1; ctl.alu_op = OP_ADD; ctl.reg_wr = 1'b1; ctl.reg_sel = RS_LINK; end
      default:                      ctl = '0;
    endcase
  end

  always_comb begin
    case (addr)
      6'd1, 6'd13, 6'd18:                          jump = JT_SPIN;
      6'd3:                                        jump = JT_DISP;
      6'd21:                                       jump = JT_FNEZ;
      6'd26:                                       jump = JT_FEQZ;
      6'd6, 6'd9, 6'd14, 6'd19, 6'd24, 6'd29,
      6'd32, 6'd35, 6'd40, 6'd45:                  jump = JT_FETCH;
      default: jump = (addr > upc_t'(45)) ? JT_FETCH : JT_NEXT;
    endcase
  end

  // R10: the store never asks two sources to drive the bus together
  always_comb begin
    p_one_driver_r10: assert ($countones({ctl.en_imm, ctl.en_alu, ctl.en_mem, ctl.en_reg}) <= 1)
      else $error("two bus drivers at micro-address %0d", addr);
  end
endmodule

// File: rtl/ucode_next_addr.sv
module ucode_next_addr
  import useq_pkg::*;
(
  input  upc_t              cur,
  input  jump_e             jump,
  input  logic              busy,
  input  logic              zero,
  input  logic [OPC_W-1:0]  opcode,
  output upc_t              nxt
);
  upc_t inc;
  assign inc = cur + upc_t'(1);

  always_comb begin
    case (jump)
      JT_NEXT:  nxt = inc;
      JT_SPIN:  nxt = busy ? cur : inc;
      JT_FETCH: nxt = FETCH_ENTRY;
      JT_DISP:  nxt = dispatch_entry(opcode);
      JT_FEQZ:  nxt = zero ? FETCH_ENTRY : inc;
      JT_FNEZ:  nxt = zero ? inc : FETCH_ENTRY;
      default:  nxt = FETCH_ENTRY;
    endcase
  end
endmodule

// File: rtl/ucode_sequencer.sv
module ucode_sequencer
  import useq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OPC_W-1:0]  opcode,
  input  logic              zero,
  input  logic              busy,
  output logic              ld_ir,
  output logic              ld_a,
  output logic              ld_b,
  output logic              ld_ma,
  output logic              en_imm,
  output logic              en_alu,
  output logic              en_mem,
  output logic              en_reg,
  output logic              mem_wr,
  output logic              reg_wr,
  output logic [RSEL_W-1:0] reg_sel,
  output logic [OP_W-1:0]   alu_op,
  output logic [EXT_W-1:0]  ext_sel,
  output logic [UPC_W-1:0]  upc
);
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;
  logic       run_q;
  upc_t       upc_q, upc_d;
  uctl_t      word, ctl;
  jump_e      jump;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) run_q <= 1'b0;
    else             run_q <= 1'b1;
  end

  ucode_store u_store (.addr(upc_q), .ctl(word), .jump(jump));

  ucode_next_addr u_next (
    .cur(upc_q), .jump(jump), .busy(busy), .zero(zero),
    .opcode(opcode), .nxt(upc_d)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  upc_q <= FETCH_ENTRY;
    else if (run_q)   upc_q <= upc_d;
  end

  assign ctl = run_q ? word : '0;

  assign ld_ir   = ctl.ld_ir;
  assign ld_a    = ctl.ld_a;
  assign ld_b    = ctl.ld_b;
  assign ld_ma   = ctl.ld_ma;
  assign en_imm  = ctl.en_imm;
  assign en_alu  = ctl.en_alu;
  assign en_mem  = ctl.en_mem;
  assign en_reg  = ctl.en_reg;
  assign mem_wr  = ctl.mem_wr;
  assign reg_wr  = ctl.reg_wr;
  assign reg_sel = ctl.reg_sel;
  assign alu_op  = ctl.alu_op;
  assign ext_sel = ctl.ext_sel;
  assign upc     = upc_q;

  p_start_at_fetch_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(run_q) |-> upc_q == FETCH_ENTRY);

  p_step_inc_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (run_q && jump == JT_NEXT) |=> upc_q == upc_t'($past(upc_q) + upc_t'(1)));

  p_spin_hold_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (run_q && jump == JT_SPIN && busy) |=> $stable(upc_q));

  p_return_fetch_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (run_q && jump == JT_FETCH) |=> upc_q == FETCH_ENTRY);

  p_fnez_miss_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (run_q && jump == JT_FNEZ && !zero) |=> upc_q == FETCH_ENTRY);

  p_feqz_hit_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (run_q && jump == JT_FEQZ && zero) |=> upc_q == FETCH_ENTRY);
endmodule

// File: tb/ucode_sequencer_bench.sv
module ucode_sequencer_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] opcode;
  logic       zero, busy;
  logic       ld_ir, ld_a, ld_b, ld_ma, en_imm, en_alu, en_mem, en_reg, mem_wr, reg_wr;
  logic [2:0] reg_sel;
  logic [1:0] alu_op, ext_sel;
  logic [5:0] upc;

  int n_chk = 0, n_fail = 0, drv_err = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ucode_sequencer u_ucode_sequencer (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .zero(zero), .busy(busy),
    .ld_ir(ld_ir), .ld_a(ld_a), .ld_b(ld_b), .ld_ma(ld_ma), .en_imm(en_imm),
    .en_alu(en_alu), .en_mem(en_mem), .en_reg(en_reg), .mem_wr(mem_wr),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .alu_op(alu_op), .ext_sel(ext_sel), .upc(upc)
  );

  // {opcode, zero, expected entry, cycles from fetch start back to fetch start}
  localparam logic [18:0] VEC [13] = '{
    {6'd0, 1'b0, 6'd4,  6'd7}, {6'd1, 1'b0, 6'd7,  6'd7},
    {6'd2, 1'b0, 6'd10, 6'd9}, {6'd3, 1'b0, 6'd15, 6'd9},
    {6'd4, 1'b1, 6'd20, 6'd9}, {6'd4, 1'b0, 6'd20, 6'd6},
    {6'd5, 1'b0, 6'd25, 6'd9}, {6'd5, 1'b1, 6'd25, 6'd6},
    {6'd6, 1'b0, 6'd30, 6'd7}, {6'd7, 1'b0, 6'd33, 6'd7},
    {6'd8, 1'b0, 6'd36, 6'd9}, {6'd9, 1'b0, 6'd41, 6'd9},
    {6'd63, 1'b0, 6'd0, 6'd4}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
    if ($countones({en_imm, en_alu, en_mem, en_reg}) > 1) drv_err++;
  endtask

  task automatic step_until(input int target);
    for (int i = 0; i < 60; i++) begin
      tick();
      if (upc == 6'(target)) break;
    end
  endtask

  function automatic int quiet();
    return int'({ld_ir, ld_a, ld_b, ld_ma, en_imm, en_alu, en_mem, en_reg, mem_wr, reg_wr});
  endfunction

  initial begin
    rst_n = 1'b0; opcode = 6'd2; zero = 1'b0; busy = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    chk(quiet() == 0, "R1 outputs quiet in reset", quiet(), 0);
    chk(upc == 6'd0, "R1 upc in reset", int'(upc), 0);
    rst_n = 1'b1;
    #1;
    chk(quiet() == 0, "R1 quiet before start", quiet(), 0);
    for (int i = 0; i < 10; i++) begin
      tick();
      if (ld_ma) break;
    end
    // R7 fetch start word
    chk(upc == 6'd0 && en_reg && ld_ma && reg_sel == 3'd4 && !ld_a, "R7 addr0", int'(upc), 0);
    busy = 1'b1;
    tick();
    chk(upc == 6'd1 && en_mem && ld_ir, "R7 addr1", int'(upc), 1);
    for (int i = 0; i < 3; i++) begin
      tick();
      chk(upc == 6'd1, "R3 hold at instruction read", int'(upc), 1);
    end
    busy = 1'b0;
    tick();
    chk(upc == 6'd2 && en_reg && ld_a && reg_sel == 3'd4, "R3/R7 addr2", int'(upc), 2);
    tick();
    chk(upc == 6'd3 && en_alu && alu_op == 2'd2 && reg_wr && reg_sel == 3'd4, "R7 addr3", int'(upc), 3);
    tick();
    chk(upc == 6'd10, "R5 load entry", int'(upc), 10);
    tick();
    chk(upc == 6'd11 && en_imm && ld_b && ext_sel == 2'd0, "R2/R8 addr11", int'(upc), 11);
    tick();
    chk(upc == 6'd12 && en_alu && alu_op == 2'd0 && ld_ma, "R8 addr12", int'(upc), 12);
    busy = 1'b1;
    tick();
    chk(upc == 6'd13 && en_mem && reg_wr && reg_sel == 3'd1, "R8 addr13", int'(upc), 13);
    tick();
    chk(upc == 6'd13, "R3 hold at memory read", int'(upc), 13);
    busy = 1'b0;
    tick();
    chk(upc == 6'd14, "R3 release", int'(upc), 14);
    tick();
    chk(upc == 6'd0, "R4 return to fetch", int'(upc), 0);

    // table walk: dispatch target (R5), branch outcome (R6), routine length
    for (int v = 0; v < 13; v++) begin
      int n;
      opcode = VEC[v][18:13];
      zero   = VEC[v][12];
      n = 0;
      do begin
        tick();
        n++;
        if (n == 4) chk(upc == VEC[v][11:6], "R5 dispatch entry", int'(upc), int'(VEC[v][11:6]));
      end while (upc != 6'd0 && n < 40);
      chk(n == int'(VEC[v][5:0]), "R6/R4 routine length", n, int'(VEC[v][5:0]));
    end

    opcode = 6'd4; zero = 1'b1;
    step_until(23);
    chk(upc == 6'd23 && en_imm && ld_b && ext_sel == 2'd2, "R9 branch offset", int'(ext_sel), 2);
    step_until(0);

    opcode = 6'd8; zero = 1'b0;
    step_until(38);
    chk(upc == 6'd38 && reg_wr && reg_sel == 3'd3 && en_alu && alu_op == 2'd0, "R11 link write", int'(reg_sel), 3);
    step_until(0);

    chk(drv_err == 0, "R10 single bus driver", drv_err, 0);

    opcode = 6'd0;
    tick(); tick();
    rst_n = 1'b0;
    #2;
    chk(quiet() == 0 && upc == 6'd0, "R1 reset mid routine", int'(upc), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule